// File: doc/BRIEF.md
# Operand-Gathering Compute Unit Sequencer

The block governs one execution slot that sits between an issue stage, a register scoreboard and an external pipelined ALU. When the slot is idle, an issue pulse hands it an opcode. The slot then becomes busy and asks the scoreboard for each source operand that the instruction actually needs. It asks with a request line per operand and takes the data in the cycle the matching grant arrives. Once every operand is present, it offers the opcode and operands to the ALU over a valid/ready handshake. It takes the ALU results over a second valid/ready handshake. It then asks the scoreboard, with a write request per result, to accept each result that is not masked. When the last write grant is seen, the slot goes idle again.

The operand and result widths, the number of operands and results, and the opcode width are parameters. The defaults are two 16-bit sources and two 16-bit results. A parameter selects whether a grant's data can reach the ALU in the grant cycle itself (bypass) or only one cycle later. With the default bypass path, the last operand grant, the ALU start and the result capture can all fall in one clock cycle.

Top module: `cu_sequencer`

## Requirements
- R1: An issue is accepted only in a cycle where issue_i is high and busy_o is low. The opcode is latched in that cycle and shown on alu_op_o from the next cycle. busy_o is high from the next cycle. An issue_i pulse while busy_o is high changes nothing.
- R2: busy_o stays high until the result has been captured and every write request raised for it has been granted. It falls on the edge after the first cycle in which both are true. If every result is masked, that cycle is the one after capture.
- R3: For each source operand whose mask bit is 0, rd_req_o bit i rises in the cycle after acceptance and stays high until rd_go_i bit i is seen. The data on rd_data_i bits [i*16 +: 16] is taken in that grant cycle, and the request falls in the next cycle. It is not raised again within the transaction.
- R4: A source whose src_mask_i bit (sampled at acceptance) is 1 is never requested and counts as available at once. Its value on the ALU side is zero.
- R5: alu_valid_o is high in the first busy cycle in which every source has been granted in that cycle or earlier, or is masked. alu_src_o bits [i*16 +: 16] carry source i (slot 0 is operand a, slot 1 is operand b), and alu_op_o carries the latched opcode.
- R6: Each accepted issue produces exactly one ALU input transfer (alu_valid_o and alu_ready_i high together). While alu_valid_o waits for alu_ready_i, it stays high and the operands and opcode stay stable.
- R7: alu_oready_o is high from the ALU input transfer cycle (inclusive) until the first cycle in which alu_ovalid_i is also high. In that cycle result j is captured from alu_res_i bits [j*16 +: 16] (o1 at j=0, o2 at j=1). After that, alu_oready_o is low for the rest of the transaction.
- R8: For each result whose dst_mask_i bit (sampled at acceptance) is 0, wr_req_o bit j rises in the cycle after capture and stays high until wr_go_i bit j is seen, then falls. wr_data_o bits [j*16 +: 16] hold the captured result. Masked results raise no request.
- R9: The last operand grant, the ALU input transfer and the result capture can complete in the same cycle.
- R10: A synchronous active-high reset clears busy_o, every read and write request, alu_valid_o and alu_oready_o.
- R11: A grant on rd_go_i or wr_go_i whose request line is low has no effect on the operands or results the unit delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue pulse |
| op_i | input | OP_W | Opcode offered with the issue pulse |
| src_mask_i | input | SRC_N | Per-source mask; 1 means the source is not needed (reads as zero) |
| dst_mask_i | input | DST_N | Per-result mask; 1 means the result is not written back |
| busy_o | output | 1 | Unit holds a transaction |
| rd_req_o | output | SRC_N | Operand read requests to the scoreboard |
| rd_go_i | input | SRC_N | Operand read grants |
| rd_data_i | input | SRC_N*WORD_W | Operand data, valid with the grant |
| alu_valid_o | output | 1 | ALU input valid |
| alu_ready_i | input | 1 | ALU input ready |
| alu_op_o | output | OP_W | Latched opcode to the ALU |
| alu_src_o | output | SRC_N*WORD_W | Operands to the ALU |
| alu_ovalid_i | input | 1 | ALU output valid |
| alu_oready_o | output | 1 | Unit ready to take the ALU output |
| alu_res_i | input | DST_N*WORD_W | ALU results |
| wr_req_o | output | DST_N | Result write requests to the scoreboard |
| wr_go_i | input | DST_N | Result write grants |
| wr_data_o | output | DST_N*WORD_W | Captured results for write-back |

## Verification
The hardest case to reach from the ports is the one where phases collapse into a single clock edge: the final operand grant, the ALU taking the operands and the ALU handing back its result all fall in one cycle. The data must then flow straight from rd_data_i to alu_src_o, and the capture must not wait for a registered ALU-done flag. The stimulus reaches this case with a phase that holds every grant, ready and output-valid line high while issuing back to back. The bench counts the cycles where all three coincide. The random phases also drive grants while no request is up, which shows that stray grants leave the delivered operands and results unchanged.

// File: rtl/cu_pkg.sv
package cu_pkg;

   localparam int unsigned CU_WORD_W = 16;
   localparam int unsigned CU_SRC_N  = 2;
   localparam int unsigned CU_DST_N  = 2;
   localparam int unsigned CU_OP_W   = 8;

   // how a granted operand reaches the ALU side
   typedef enum logic [0:0] {
      OPND_LATCHED = 1'b0,   // only from the holding register, one cycle after the grant
      OPND_BYPASS  = 1'b1    // straight from the grant data in the grant cycle
   } opnd_path_e;

endpackage

// File: rtl/cu_src_slot.sv
module cu_src_slot
   import cu_pkg::*;
#(
   parameter int unsigned WORD_W    = CU_WORD_W,
   parameter opnd_path_e  OPND_PATH = OPND_BYPASS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy_i,
   input  logic              accept_i,
   input  logic              mask_i,
   input  logic              go_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              req_o,
   output logic              avail_o,
   output logic [WORD_W-1:0] value_o
);

   logic              req_q;
   logic              avail_q;
   logic              grant;
   logic [WORD_W-1:0] data_q;

   assign grant = req_q & go_i;
   assign req_o = req_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q   <= 1'b0;
         avail_q <= 1'b0;
         data_q  <= '0;
      end else if (accept_i) begin
         req_q   <= ~mask_i;
         avail_q <= mask_i;
         data_q  <= '0;
      end else if (grant) begin
         req_q   <= 1'b0;
         avail_q <= 1'b1;
         data_q  <= data_i;
      end
   end

   generate
      if (OPND_PATH == OPND_BYPASS) begin : g_bypass
         assign avail_o = avail_q | grant;
         assign value_o = grant ? data_i : data_q;
      end else begin : g_latched
         assign avail_o = avail_q;
         assign value_o = data_q;
      end
   endgenerate

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      req_q && !go_i |=> req_q);
   // R3
   rd_drop_chk: assert property (@(posedge clk) disable iff (rst)
      req_q && go_i |=> !req_q && avail_q && data_q == $past(data_i));
   // R4
   rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
      accept_i && mask_i |=> !req_q && avail_q && data_q == '0);
   // R10
   rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_i |-> !req_q);

endmodule

// File: rtl/cu_dst_slot.sv
module cu_dst_slot
   import cu_pkg::*;
#(
   parameter int unsigned WORD_W = CU_WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy_i,
   input  logic              capture_i,
   input  logic              mask_i,
   input  logic              go_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              req_o,
   output logic              clear_o,
   output logic [WORD_W-1:0] data_o
);

   logic              req_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q  <= 1'b0;
         data_q <= '0;
      end else if (capture_i) begin
         req_q  <= ~mask_i;
         data_q <= data_i;
      end else if (req_q && go_i) begin
         req_q  <= 1'b0;
      end
   end

   assign req_o   = req_q;
   assign clear_o = ~req_q | go_i;
   assign data_o  = data_q;

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      req_q && !go_i |=> req_q);
   // R8
   wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
      req_q && go_i |=> !req_q);
   // R8
   wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
      capture_i && mask_i |=> !req_q);
   // R8
   wr_data_chk: assert property (@(posedge clk) disable iff (rst)
      req_q |=> $stable(data_q));
   // R10
   wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_i |-> !req_q);

endmodule

// File: rtl/cu_phase_ctrl.sv
module cu_phase_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic issue_i,
   input  logic all_avail_i,
   input  logic alu_ready_i,
   input  logic alu_ovalid_i,
   input  logic all_clear_i,
   output logic accept_o,
   output logic busy_o,
   output logic alu_valid_o,
   output logic alu_fire_o,
   output logic oready_o,
   output logic capture_o
);

   logic busy_q;
   logic alu_done_q;
   logic res_q;
   logic retire;

   assign accept_o    = issue_i & ~busy_q;
   assign alu_valid_o = busy_q & all_avail_i & ~alu_done_q;
   assign alu_fire_o  = alu_valid_o & alu_ready_i;
   assign oready_o    = busy_q & (alu_done_q | alu_fire_o) & ~res_q;
   assign capture_o   = oready_o & alu_ovalid_i;
   assign retire      = busy_q & res_q & all_clear_i;
   assign busy_o      = busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q     <= 1'b0;
         alu_done_q <= 1'b0;
         res_q      <= 1'b0;
      end else if (accept_o) begin
         busy_q     <= 1'b1;
         alu_done_q <= 1'b0;
         res_q      <= 1'b0;
      end else begin
         if (alu_fire_o) alu_done_q <= 1'b1;
         if (capture_o)  res_q      <= 1'b1;
         if (retire)     busy_q     <= 1'b0;
      end
   end

   // R1
   accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
      accept_o |=> busy_o);
   // R6
   one_alu_chk: assert property (@(posedge clk) disable iff (rst)
      alu_fire_o |=> !alu_valid_o);
   // R7
   one_capture_chk: assert property (@(posedge clk) disable iff (rst)
      capture_o |=> !oready_o);
   // R2
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q && !res_q |=> busy_q);

endmodule

// File: rtl/cu_sequencer.sv
module cu_sequencer
   import cu_pkg::*;
#(
   parameter int unsigned WORD_W    = CU_WORD_W,
   parameter int unsigned SRC_N     = CU_SRC_N,
   parameter int unsigned DST_N     = CU_DST_N,
   parameter int unsigned OP_W      = CU_OP_W,
   parameter opnd_path_e  OPND_PATH = OPND_BYPASS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    issue_i,
   input  logic [OP_W-1:0]         op_i,
   input  logic [SRC_N-1:0]        src_mask_i,
   input  logic [DST_N-1:0]        dst_mask_i,
   output logic                    busy_o,
   output logic [SRC_N-1:0]        rd_req_o,
   input  logic [SRC_N-1:0]        rd_go_i,
   input  logic [SRC_N*WORD_W-1:0] rd_data_i,
   output logic                    alu_valid_o,
   input  logic                    alu_ready_i,
   output logic [OP_W-1:0]         alu_op_o,
   output logic [SRC_N*WORD_W-1:0] alu_src_o,
   input  logic                    alu_ovalid_i,
   output logic                    alu_oready_o,
   input  logic [DST_N*WORD_W-1:0] alu_res_i,
   output logic [DST_N-1:0]        wr_req_o,
   input  logic [DST_N-1:0]        wr_go_i,
   output logic [DST_N*WORD_W-1:0] wr_data_o
);

   localparam int unsigned SRC_BITS = SRC_N * WORD_W;
   localparam int unsigned DST_BITS = DST_N * WORD_W;

   generate
      if (WORD_W < 1) begin : g_bad_word
         $error("cu_sequencer: WORD_W must be at least 1");
      end
      if (SRC_N < 1) begin : g_bad_src
         $error("cu_sequencer: SRC_N must be at least 1");
      end
      if (DST_N < 1) begin : g_bad_dst
         $error("cu_sequencer: DST_N must be at least 1");
      end
      if (OP_W < 1) begin : g_bad_op
         $error("cu_sequencer: OP_W must be at least 1");
      end
      if (SRC_BITS != $bits(rd_data_i) || DST_BITS != $bits(alu_res_i)) begin : g_bad_bus
         $error("cu_sequencer: bus widths do not match the slot counts");
      end
   endgenerate

   logic             accept;
   logic             alu_fire;
   logic             capture;
   logic [SRC_N-1:0] avail;
   logic [DST_N-1:0] clear;
   logic [OP_W-1:0]  op_q;
   logic [DST_N-1:0] dmask_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q    <= '0;
         dmask_q <= '0;
      end else if (accept) begin
         op_q    <= op_i;
         dmask_q <= dst_mask_i;
      end
   end

   assign alu_op_o = op_q;

   cu_phase_ctrl i_phase (
      .clk          (clk),
      .rst          (rst),
      .issue_i      (issue_i),
      .all_avail_i  (&avail),
      .alu_ready_i  (alu_ready_i),
      .alu_ovalid_i (alu_ovalid_i),
      .all_clear_i  (&clear),
      .accept_o     (accept),
      .busy_o       (busy_o),
      .alu_valid_o  (alu_valid_o),
      .alu_fire_o   (alu_fire),
      .oready_o     (alu_oready_o),
      .capture_o    (capture)
   );

   generate
      for (genvar s = 0; s < SRC_N; s++) begin : g_src
         cu_src_slot #(
            .WORD_W    (WORD_W),
            .OPND_PATH (OPND_PATH)
         ) i_src (
            .clk      (clk),
            .rst      (rst),
            .busy_i   (busy_o),
            .accept_i (accept),
            .mask_i   (src_mask_i[s]),
            .go_i     (rd_go_i[s]),
            .data_i   (rd_data_i[s*WORD_W +: WORD_W]),
            .req_o    (rd_req_o[s]),
            .avail_o  (avail[s]),
            .value_o  (alu_src_o[s*WORD_W +: WORD_W])
         );
      end
      for (genvar d = 0; d < DST_N; d++) begin : g_dst
         cu_dst_slot #(
            .WORD_W (WORD_W)
         ) i_dst (
            .clk       (clk),
            .rst       (rst),
            .busy_i    (busy_o),
            .capture_i (capture),
            .mask_i    (dmask_q[d]),
            .go_i      (wr_go_i[d]),
            .data_i    (alu_res_i[d*WORD_W +: WORD_W]),
            .req_o     (wr_req_o[d]),
            .clear_o   (clear[d]),
            .data_o    (wr_data_o[d*WORD_W +: WORD_W])
         );
      end
   endgenerate

   // R1
   opcode_latch_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> alu_op_o == $past(op_i));
   // R1
   busy_issue_chk: assert property (@(posedge clk) disable iff (rst)
      busy_o && issue_i |=> $stable(alu_op_o));
   // R6
   alu_hold_chk: assert property (@(posedge clk) disable iff (rst)
      alu_valid_o && !alu_ready_i |=> alu_valid_o && $stable(alu_src_o) && $stable(alu_op_o));
   // R2
   wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (|wr_req_o) |-> busy_o);
   // R7
   capture_order_chk: assert property (@(posedge clk) disable iff (rst)
      alu_oready_o |-> busy_o && !alu_valid_o | alu_ready_i);

endmodule

// File: tb/test_cu_sequencer.sv
module test_cu_sequencer;

   localparam int W  = 16;
   localparam int NS = 2;
   localparam int ND = 2;
   localparam int OW = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              issue_i = 1'b0;
   logic [OW-1:0]     op_i = '0;
   logic [NS-1:0]     src_mask_i = '0;
   logic [ND-1:0]     dst_mask_i = '0;
   logic              busy_o;
   logic [NS-1:0]     rd_req_o;
   logic [NS-1:0]     rd_go_i = '0;
   logic [NS*W-1:0]   rd_data_i = '0;
   logic              alu_valid_o;
   logic              alu_ready_i = 1'b0;
   logic [OW-1:0]     alu_op_o;
   logic [NS*W-1:0]   alu_src_o;
   logic              alu_ovalid_i = 1'b0;
   logic              alu_oready_o;
   logic [ND*W-1:0]   alu_res_i = '0;
   logic [ND-1:0]     wr_req_o;
   logic [ND-1:0]     wr_go_i = '0;
   logic [ND*W-1:0]   wr_data_o;

   always #10 clk = ~clk;

   cu_sequencer i_cu_sequencer (
      .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i),
      .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i), .busy_o(busy_o),
      .rd_req_o(rd_req_o), .rd_go_i(rd_go_i), .rd_data_i(rd_data_i),
      .alu_valid_o(alu_valid_o), .alu_ready_i(alu_ready_i), .alu_op_o(alu_op_o),
      .alu_src_o(alu_src_o), .alu_ovalid_i(alu_ovalid_i), .alu_oready_o(alu_oready_o),
      .alu_res_i(alu_res_i), .wr_req_o(wr_req_o), .wr_go_i(wr_go_i), .wr_data_o(wr_data_o)
   );

   int n_chk = 0, n_fail = 0;
   int n_acc = 0, n_alu = 0, n_wb = 0, n_wb_exp = 0;
   int n_same = 0, n_ign = 0, n_busy_issue = 0;
   bit done = 1'b0;

   int unsigned p_issue, p_go, p_rdy, p_ov, p_wgo;
   bit all_masked;

   // reference state
   logic              m_busy, m_alu_done, m_res;
   logic [NS-1:0]     m_rdreq, m_avail;
   logic [NS*W-1:0]   m_opnd;
   logic [ND-1:0]     m_wrreq, m_dmask;
   logic [ND*W-1:0]   m_wdata;
   logic [OW-1:0]     m_op;

   function automatic bit roll(input int unsigned pct);
      return ($urandom % 100) < pct;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_busy = 0; m_alu_done = 0; m_res = 0;
      m_rdreq = '0; m_avail = '0; m_opnd = '0;
      m_wrreq = '0; m_dmask = '0; m_wdata = '0; m_op = '0;
      n_acc = 0; n_alu = 0; n_wb = 0; n_wb_exp = 0;
   endtask

   task automatic do_reset(input int n);
      @(negedge clk);
      rst = 1'b1; issue_i = 0; rd_go_i = '0; alu_ready_i = 0; alu_ovalid_i = 0; wr_go_i = '0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
         // R10: everything idle while reset is applied
         check("R10 busy", busy_o, 0);
         check("R10 rd_req", rd_req_o, 0);
         check("R10 alu_valid", alu_valid_o, 0);
         check("R10 oready", alu_oready_o, 0);
         check("R10 wr_req", wr_req_o, 0);
      end
      rst = 1'b0;
      model_reset();
   endtask

   task automatic step(input bit allow_issue);
      logic [NS-1:0]   fr;
      logic [NS*W-1:0] ev;
      logic            allav, eav, eaf, eor, ecap, eclr, acc;
      @(negedge clk);
      issue_i = allow_issue && roll(p_issue);
      op_i    = OW'($urandom);
      for (int i = 0; i < NS; i++) src_mask_i[i] = all_masked | roll(25);
      for (int j = 0; j < ND; j++) dst_mask_i[j] = all_masked | roll(25);
      // R11: grants are rolled whether or not a request is up
      for (int i = 0; i < NS; i++) rd_go_i[i] = roll(p_go);
      rd_data_i    = (NS*W)'({$urandom, $urandom});
      alu_ready_i  = roll(p_rdy);
      alu_ovalid_i = roll(p_ov);
      alu_res_i    = (ND*W)'({$urandom, $urandom});
      for (int j = 0; j < ND; j++) wr_go_i[j] = roll(p_wgo);
      #1;
      allav = 1'b1;
      for (int i = 0; i < NS; i++) begin
         fr[i] = m_rdreq[i] & rd_go_i[i];
         allav = allav & (m_avail[i] | fr[i]);
         ev[i*W +: W] = fr[i] ? rd_data_i[i*W +: W] : m_opnd[i*W +: W];
      end
      eav  = m_busy & allav & ~m_alu_done;
      eaf  = eav & alu_ready_i;
      eor  = m_busy & (m_alu_done | eaf) & ~m_res;
      ecap = eor & alu_ovalid_i;
      eclr = &(~m_wrreq | wr_go_i);
      acc  = issue_i & ~m_busy;

      check("R2 busy", busy_o, m_busy);
      check("R3,R4 rd_req", rd_req_o, m_rdreq);
      check("R5 alu_valid", alu_valid_o, eav);
      if (eav) begin
         check("R5 operands", alu_src_o, ev);
         check("R1 opcode", alu_op_o, m_op);
      end
      check("R7 oready", alu_oready_o, eor);
      check("R8 wr_req", wr_req_o, m_wrreq);
      if (|m_wrreq) check("R8 wr_data", wr_data_o, m_wdata);

      n_acc += int'(acc);
      n_alu += int'(eaf);
      n_wb  += $countones(m_wrreq & wr_go_i);
      if (m_busy && issue_i) n_busy_issue++;
      if (m_busy && |(rd_go_i & ~m_rdreq)) n_ign++;
      if (|fr && eaf && ecap) n_same++;

      if (acc) begin
         m_busy = 1; m_op = op_i; m_dmask = dst_mask_i;
         m_rdreq = ~src_mask_i; m_avail = src_mask_i; m_opnd = '0;
         m_alu_done = 0; m_res = 0;
      end else begin
         for (int i = 0; i < NS; i++)
            if (fr[i]) begin
               m_rdreq[i] = 0; m_avail[i] = 1; m_opnd[i*W +: W] = rd_data_i[i*W +: W];
            end
         if (eaf) m_alu_done = 1;
         if (m_busy && m_res && eclr) m_busy = 0;
         m_wrreq = m_wrreq & ~wr_go_i;
         if (ecap) begin
            m_res = 1; m_wdata = alu_res_i; m_wrreq = ~m_dmask;
            n_wb_exp += $countones(~m_dmask);
         end
      end
   endtask

   task automatic run(input int n, input bit allow_issue);
      for (int c = 0; c < n; c++) step(allow_issue);
   endtask

   task automatic set_p(input int unsigned pi, pg, pr, po, pw);
      p_issue = pi; p_go = pg; p_rdy = pr; p_ov = po; p_wgo = pw;
   endtask

   task automatic drain_and_count(input string tag);
      set_p(0, 100, 100, 100, 100);
      all_masked = 0;
      run(40, 1'b0);
      // R6: one ALU transfer per accepted issue
      check({tag, " R6 alu transfers"}, n_alu, n_acc);
      // R8: one write-back per unmasked result
      check({tag, " R8 write-backs"}, n_wb, n_wb_exp);
   endtask

   initial begin
      void'($urandom(32'h1c0ffee5));
      model_reset();
      all_masked = 0;
      set_p(40, 50, 50, 50, 50);
      do_reset(3);

      run(3000, 1'b1);                 // mixed random
      do_reset(2);                     // R10 reset mid-run
      set_p(100, 100, 100, 100, 100);  // R9 every handshake immediate
      run(500, 1'b1);
      drain_and_count("fast");
      do_reset(1);
      all_masked = 1;                  // R4 nothing to fetch or write
      set_p(60, 50, 50, 50, 50);
      run(300, 1'b1);
      drain_and_count("masked");
      do_reset(1);
      set_p(30, 10, 20, 15, 10);       // slow handshakes
      run(2000, 1'b1);
      drain_and_count("slow");

      // R9
      check("R9 same-cycle grant/start/capture seen", n_same > 0, 1);
      // R11
      check("R11 stray grants exercised", n_ign > 0, 1);
      // R1
      check("R1 issue while busy exercised", n_busy_issue > 0, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule